// File: doc/BRIEF.md
# Ballast Phase Sequencer

This block walks the half-bridge of a fluorescent lamp ballast through its operating phases: off, preheat, ignition, run and latched-off. It replaces the external RC timing capacitor with a level counter. The counter ramps up to an upper level and then falls back to a lower level. It falls at a slow rate for preheat and for full fault timing, and at a fast rate for the reduced fault cycle. Preheat ends when the counter reaches the lower level. A fault is never acted on at once, except for anti-saturation. A fault instead launches a counter cycle, and when that cycle ends the block samples the condition again, against a lowered level for current faults. It latches only if the condition is still present.

All inputs are synchronous comparator flags from an analog front end. The outputs drive the oscillator and the drivers: a preheat-frequency select, a frequency-increase request for current regulation, and a half-bridge enable. The phase code and a latch flag complete the outputs. The states are OFF, PREHEAT, IGNITE, RUN and LATCHED. The transitions are:

- power-up: OFF to PREHEAT.
- preheat-done: PREHEAT to IGNITE.
- ignition-done: IGNITE to RUN.
- fault-latch: IGNITE or RUN to LATCHED.
- shutdown: any non-latched state to OFF.
- power-loss: any state to OFF.

Top module: `ballast_phase_seq`

## Requirements
- R1: After reset the phase code is 0 (OFF). hb_en, pre_freq_sel, freq_up and latched are all 0. The phase codes are OFF=0, PREHEAT=1, IGNITE=2, RUN=3, LATCHED=4.
- R2: With supply_ok high and shutdown_req low, OFF moves to PREHEAT on the next edge. In PREHEAT, pre_freq_sel and hb_en are 1. PREHEAT moves to IGNITE exactly 1 + TOP_LVL + SLOW_DIV*(TOP_LVL-LOW_LVL) cycles after it was entered (77 with the defaults).
- R3: In IGNITE, pre_freq_sel is 0. eoi_reached moves the block to RUN on the next edge.
- R4: In IGNITE, freq_up follows ihb_lim_hi in the same cycle. ihb_lim_hi also starts a reduced counter cycle, which ends 1 + 2*TOP_LVL - LOW_LVL cycles after its start edge (35 with the defaults). At that edge the block latches if ihb_lim_lo is high. Otherwise it stays in IGNITE.
- R5: An eoi_reached that arrives during a reduced cycle, including in the cycle in which that cycle ends, moves the block to RUN and discards the cycle. The next fault in RUN therefore gets a fresh, complete cycle.
- R6: In RUN, freq_up follows ihb_lim_lo in the same cycle. ihb_lim_lo also starts a reduced cycle. At the end of that cycle the block latches if ihb_chk_lo is high.
- R7: In RUN, eol_viol starts a full cycle of the same length as preheat. The block latches at its end only if eol_viol is still high. eol_viol has no effect in PREHEAT or IGNITE.
- R8: In RUN, sovp_flag starts a full cycle. The block latches at its end only if sovp_flag is still high.
- R9: Anti-saturation latches the block on the next edge: ihb_sat in IGNITE, or ihb_cap_mode in RUN. Anti-saturation takes priority over eoi_reached.
- R10: shutdown_req in any non-latched state moves the block to OFF on the next edge and holds it there. On release, the block restarts in PREHEAT. In LATCHED, shutdown_req has no effect.
- R11: In LATCHED, latched is 1 and hb_en is 0. Only a low supply_ok leaves this state, and it moves the block to OFF on the next edge. A low supply_ok moves every other state to OFF as well.
- R12: In PREHEAT, the current, EOL and over-voltage flags have no effect: freq_up stays 0 and the block does not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above the under-voltage lockout level |
| shutdown_req | input | 1 | External stop request |
| eoi_reached | input | 1 | Ignition sweep has reached its end level |
| ihb_chk_lo | input | 1 | Half-bridge current above the run-mode recheck level |
| ihb_lim_lo | input | 1 | Current above the run limit, also used as the ignition recheck level |
| ihb_lim_hi | input | 1 | Current above the ignition limit |
| ihb_sat | input | 1 | Current above the anti-saturation level |
| ihb_cap_mode | input | 1 | Long current spike above the ignition limit (capacitive mode) |
| eol_viol | input | 1 | Lamp end-of-life window violated |
| sovp_flag | input | 1 | Static over-voltage present |
| phase | output | 3 | Phase code |
| pre_freq_sel | output | 1 | Select the preheat frequency |
| freq_up | output | 1 | Request a frequency increase |
| hb_en | output | 1 | Half-bridge switching enable |
| latched | output | 1 | Latched-off indication |

## Verification
Two events can land on the same edge: the end of a reduced fault cycle, and the arrival of end-of-ignition. The bench holds the ignition current flags long enough for the cycle to reach its last cycle, and raises eoi_reached exactly then. It requires RUN rather than LATCHED on the following edge. A second collision pairs anti-saturation with end-of-ignition, and there LATCHED must win. Full sweeps over the five current flags in ignition and in run also check the same-cycle frequency request and the one-edge latch reaction for every combination of flags.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_PREHEAT = 3'd1,
        PH_IGNITE  = 3'd2,
        PH_RUN     = 3'd3,
        PH_LATCHED = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        TRIP_NONE    = 2'd0,
        TRIP_CURRENT = 2'd1,
        TRIP_EOL     = 2'd2,
        TRIP_OVP     = 2'd3
    } trip_e;

endpackage

// File: rtl/bsq_cap_timer.sv
// Emulated timing capacitor: ramps up one level per cycle to TOP_LVL, then
// falls to LOW_LVL either one level per cycle (fast) or one per SLOW_DIV.
module bsq_cap_timer #(
    parameter int TOP_LVL  = 20,
    parameter int LOW_LVL  = 6,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic fast_dis,
    output logic busy,
    output logic at_low
);
    localparam int LW = $clog2(TOP_LVL + 1);

    logic [LW-1:0] lvl_q;
    logic          run_q;
    logic          fall_q;
    logic          fast_q;
    logic          slow_tick;
    logic          dn_ok;

    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam int DW = $clog2(SLOW_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (clr || !(run_q && fall_q) || slow_tick) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign slow_tick = (div_q == DW'(SLOW_DIV - 1));
        end else begin : g_nodiv
            assign slow_tick = 1'b1;
        end
    endgenerate

    assign dn_ok  = fast_q || slow_tick;
    assign at_low = run_q && fall_q && (lvl_q == LW'(LOW_LVL));
    assign busy   = run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            run_q  <= 1'b0;
            fall_q <= 1'b0;
            fast_q <= 1'b0;
        end else if (clr) begin
            lvl_q  <= '0;
            run_q  <= 1'b0;
            fall_q <= 1'b0;
        end else if (start && !run_q) begin
            lvl_q  <= '0;
            run_q  <= 1'b1;
            fall_q <= 1'b0;
            fast_q <= fast_dis;
        end else if (at_low) begin
            lvl_q  <= '0;
            run_q  <= 1'b0;
            fall_q <= 1'b0;
        end else if (run_q && !fall_q) begin
            lvl_q <= lvl_q + 1'b1;
            if (lvl_q == LW'(TOP_LVL - 1)) begin
                fall_q <= 1'b1;
            end
        end else if (run_q && dn_ok) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

endmodule

// File: rtl/bsq_fault_eval.sv
// Phase-qualified fault decoding: new trip cause, immediate anti-saturation,
// recheck result for the stored cause, and the frequency-increase request.
module bsq_fault_eval
    import bsq_pkg::*;
(
    input  phase_e phase,
    input  trip_e  cause_q,
    input  logic   ihb_chk_lo,
    input  logic   ihb_lim_lo,
    input  logic   ihb_lim_hi,
    input  logic   ihb_sat,
    input  logic   ihb_cap_mode,
    input  logic   eol_viol,
    input  logic   sovp_flag,
    output trip_e  trip_req,
    output logic   sat_trip,
    output logic   cond_holds,
    output logic   freq_up
);
    always_comb begin
        trip_req = TRIP_NONE;
        sat_trip = 1'b0;
        freq_up  = 1'b0;
        case (phase)
            PH_IGNITE: begin
                sat_trip = ihb_sat;
                freq_up  = ihb_lim_hi;
                if (ihb_lim_hi) trip_req = TRIP_CURRENT;
            end
            PH_RUN: begin
                sat_trip = ihb_cap_mode;
                freq_up  = ihb_lim_lo;
                if (ihb_lim_lo)     trip_req = TRIP_CURRENT;
                else if (eol_viol)  trip_req = TRIP_EOL;
                else if (sovp_flag) trip_req = TRIP_OVP;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (cause_q)
            TRIP_CURRENT: cond_holds = (phase == PH_IGNITE) ? ihb_lim_lo : ihb_chk_lo;
            TRIP_EOL:     cond_holds = eol_viol;
            TRIP_OVP:     cond_holds = sovp_flag;
            default:      cond_holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/ballast_phase_seq.sv
module ballast_phase_seq
    import bsq_pkg::*;
#(
    parameter int TOP_LVL  = 20,
    parameter int LOW_LVL  = 6,
    parameter int SLOW_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       shutdown_req,
    input  logic       eoi_reached,
    input  logic       ihb_chk_lo,
    input  logic       ihb_lim_lo,
    input  logic       ihb_lim_hi,
    input  logic       ihb_sat,
    input  logic       ihb_cap_mode,
    input  logic       eol_viol,
    input  logic       sovp_flag,
    output logic [2:0] phase,
    output logic       pre_freq_sel,
    output logic       freq_up,
    output logic       hb_en,
    output logic       latched
);
    phase_e st_q, st_d;
    trip_e  cause_q, cause_d;
    trip_e  trip_req;
    logic   sat_trip, cond_holds, fup;
    logic   tmr_start, tmr_clr, tmr_fast, tmr_busy, tmr_low;

    bsq_cap_timer #(
        .TOP_LVL (TOP_LVL),
        .LOW_LVL (LOW_LVL),
        .SLOW_DIV(SLOW_DIV)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .start   (tmr_start),
        .fast_dis(tmr_fast),
        .busy    (tmr_busy),
        .at_low  (tmr_low)
    );

    bsq_fault_eval u_eval (
        .phase       (st_q),
        .cause_q     (cause_q),
        .ihb_chk_lo  (ihb_chk_lo),
        .ihb_lim_lo  (ihb_lim_lo),
        .ihb_lim_hi  (ihb_lim_hi),
        .ihb_sat     (ihb_sat),
        .ihb_cap_mode(ihb_cap_mode),
        .eol_viol    (eol_viol),
        .sovp_flag   (sovp_flag),
        .trip_req    (trip_req),
        .sat_trip    (sat_trip),
        .cond_holds  (cond_holds),
        .freq_up     (fup)
    );

    // Next state and timer control
    always_comb begin
        st_d      = st_q;
        cause_d   = cause_q;
        tmr_start = 1'b0;
        tmr_clr   = 1'b0;
        tmr_fast  = 1'b0;
        if (!supply_ok) begin
            st_d    = PH_OFF;
            tmr_clr = 1'b1;
            cause_d = TRIP_NONE;
        end else if (shutdown_req && st_q != PH_LATCHED) begin
            st_d    = PH_OFF;
            tmr_clr = 1'b1;
            cause_d = TRIP_NONE;
        end else begin
            unique case (st_q)
                PH_OFF: begin
                    st_d      = PH_PREHEAT;
                    tmr_start = 1'b1;
                end
                PH_PREHEAT: begin
                    if (tmr_low) st_d = PH_IGNITE;
                end
                PH_IGNITE: begin
                    if (sat_trip) begin
                        st_d    = PH_LATCHED;
                        tmr_clr = 1'b1;
                    end else if (eoi_reached) begin
                        st_d    = PH_RUN;
                        tmr_clr = 1'b1;
                        cause_d = TRIP_NONE;
                    end else if (tmr_low) begin
                        if (cond_holds) st_d = PH_LATCHED;
                        cause_d = TRIP_NONE;
                    end else if (!tmr_busy && trip_req != TRIP_NONE) begin
                        tmr_start = 1'b1;
                        tmr_fast  = 1'b1;
                        cause_d   = trip_req;
                    end
                end
                PH_RUN: begin
                    if (sat_trip) begin
                        st_d    = PH_LATCHED;
                        tmr_clr = 1'b1;
                    end else if (tmr_low) begin
                        if (cond_holds) st_d = PH_LATCHED;
                        cause_d = TRIP_NONE;
                    end else if (!tmr_busy && trip_req != TRIP_NONE) begin
                        tmr_start = 1'b1;
                        tmr_fast  = (trip_req == TRIP_CURRENT);
                        cause_d   = trip_req;
                    end
                end
                PH_LATCHED: ;
                default: begin
                    st_d    = PH_OFF;
                    tmr_clr = 1'b1;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PH_OFF;
            cause_q <= TRIP_NONE;
        end else begin
            st_q    <= st_d;
            cause_q <= cause_d;
        end
    end

    // Outputs
    always_comb begin
        phase        = st_q;
        pre_freq_sel = (st_q == PH_PREHEAT);
        hb_en        = (st_q == PH_PREHEAT) || (st_q == PH_IGNITE) || (st_q == PH_RUN);
        latched      = (st_q == PH_LATCHED);
        freq_up      = fup;
    end

endmodule

// File: rtl/ballast_phase_seq_chk.sv
module ballast_phase_seq_chk
    import bsq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       shutdown_req,
    input logic       eoi_reached,
    input logic       ihb_sat,
    input logic       ihb_cap_mode,
    input logic [2:0] phase,
    input logic       latched
);
    AST_POWER_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> phase == PH_OFF); // R11

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        latched && supply_ok |=> latched); // R11

    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok && shutdown_req && !latched |=> phase == PH_OFF); // R10

    AST_PREHEAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PREHEAT |=> phase inside {PH_PREHEAT, PH_IGNITE, PH_OFF}); // R2

    AST_IGNITE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IGNITE && supply_ok && !shutdown_req && eoi_reached && !ihb_sat
        |=> phase == PH_RUN); // R3

    AST_SAT_IGNITE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IGNITE && supply_ok && !shutdown_req && ihb_sat |=> latched); // R9

    AST_SAT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_RUN && supply_ok && !shutdown_req && ihb_cap_mode |=> latched); // R9

    AST_LATCH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(phase) inside {PH_IGNITE, PH_RUN}); // R4
endmodule

bind ballast_phase_seq ballast_phase_seq_chk u_chk (.*);

// File: tb/ballast_phase_seq_bench.sv
module ballast_phase_seq_bench;
    localparam int TOP  = 20;
    localparam int LOW  = 6;
    localparam int DIV  = 4;
    localparam int PRE_CYC  = 1 + TOP + DIV * (TOP - LOW);
    localparam int FAST_CYC = 1 + TOP + (TOP - LOW);
    localparam int P_OFF = 0, P_PRE = 1, P_IGN = 2, P_RUN = 3, P_LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, shutdown_req = 1'b0, eoi_reached = 1'b0;
    logic ihb_chk_lo = 1'b0, ihb_lim_lo = 1'b0, ihb_lim_hi = 1'b0;
    logic ihb_sat = 1'b0, ihb_cap_mode = 1'b0, eol_viol = 1'b0, sovp_flag = 1'b0;
    logic [2:0] phase;
    logic pre_freq_sel, freq_up, hb_en, latched;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ballast_phase_seq #(.TOP_LVL(TOP), .LOW_LVL(LOW), .SLOW_DIV(DIV)) u_ballast_phase_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shutdown_req(shutdown_req),
        .eoi_reached(eoi_reached), .ihb_chk_lo(ihb_chk_lo), .ihb_lim_lo(ihb_lim_lo),
        .ihb_lim_hi(ihb_lim_hi), .ihb_sat(ihb_sat), .ihb_cap_mode(ihb_cap_mode),
        .eol_viol(eol_viol), .sovp_flag(sovp_flag), .phase(phase),
        .pre_freq_sel(pre_freq_sel), .freq_up(freq_up), .hb_en(hb_en), .latched(latched)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_flags();
        shutdown_req = 0; eoi_reached = 0; ihb_chk_lo = 0; ihb_lim_lo = 0;
        ihb_lim_hi = 0; ihb_sat = 0; ihb_cap_mode = 0; eol_viol = 0; sovp_flag = 0;
    endtask

    task automatic wait_phase(input int p, output int n);
        n = 0;
        do begin tick(); n++; end while (int'(phase) != p && n < 2000);
    endtask

    task automatic wait_latch(output int n);
        n = 0;
        do begin tick(); n++; end while (!latched && n < 2000);
    endtask

    task automatic go_ignite();
        int n;
        clear_flags();
        supply_ok = 0;
        tick();
        supply_ok = 1;
        wait_phase(P_IGN, n);
    endtask

    task automatic go_run();
        go_ignite();
        eoi_reached = 1;
        tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        // R1 reset state
        tick(); tick();
        check_eq("R1 phase", int'(phase), P_OFF);
        check_eq("R1 hb_en", int'(hb_en), 0);
        check_eq("R1 pre_freq_sel", int'(pre_freq_sel), 0);
        check_eq("R1 latched", int'(latched), 0);
        check_eq("R1 freq_up", int'(freq_up), 0);
        rst_n = 1;
        tick();

        // R2 preheat entry and length
        supply_ok = 1;
        tick();
        check_eq("R2 phase", int'(phase), P_PRE);
        check_eq("R2 pre_freq_sel", int'(pre_freq_sel), 1);
        check_eq("R2 hb_en", int'(hb_en), 1);
        wait_phase(P_IGN, n);
        check_eq("R2 preheat length", n + 1, PRE_CYC + 1);
        check_eq("R3 pre_freq_sel low", int'(pre_freq_sel), 0);

        // R3 ignition to run
        eoi_reached = 1;
        tick();
        check_eq("R3 run", int'(phase), P_RUN);

        // R12 preheat ignores faults
        clear_flags();
        supply_ok = 0; tick(); supply_ok = 1; tick();
        ihb_chk_lo = 1; ihb_lim_lo = 1; ihb_lim_hi = 1; ihb_sat = 1;
        ihb_cap_mode = 1; eol_viol = 1; sovp_flag = 1;
        #1;
        check_eq("R12 freq_up", int'(freq_up), 0);
        repeat (10) tick();
        check_eq("R12 phase", int'(phase), P_PRE);
        check_eq("R12 latched", int'(latched), 0);

        // Sweep over current flags in ignition: R4 request, R9 latch
        for (int v = 0; v < 32; v++) begin
            go_ignite();
            ihb_chk_lo = v[0]; ihb_lim_lo = v[1]; ihb_lim_hi = v[2];
            ihb_sat = v[3]; ihb_cap_mode = v[4];
            #1;
            check_eq("R4 ignite freq_up", int'(freq_up), int'(v[2]));
            tick();
            check_eq("R9 ignite latch", int'(latched), int'(v[3]));
        end

        // Sweep over current flags in run: R6 request, R9 latch
        for (int v = 0; v < 32; v++) begin
            go_run();
            ihb_chk_lo = v[0]; ihb_lim_lo = v[1]; ihb_lim_hi = v[2];
            ihb_sat = v[3]; ihb_cap_mode = v[4];
            #1;
            check_eq("R6 run freq_up", int'(freq_up), int'(v[1]));
            tick();
            check_eq("R9 run latch", int'(latched), int'(v[4]));
        end

        // R4 reduced cycle latch in ignition
        go_ignite();
        ihb_lim_hi = 1; ihb_lim_lo = 1;
        wait_latch(n);
        check_eq("R4 reduced cycle latch time", n, FAST_CYC + 1);

        // R4 current gone before the recheck
        go_ignite();
        ihb_lim_hi = 1; ihb_lim_lo = 1;
        repeat (5) tick();
        ihb_lim_hi = 0; ihb_lim_lo = 0;
        repeat (40) tick();
        check_eq("R4 no latch phase", int'(phase), P_IGN);
        check_eq("R4 no latch flag", int'(latched), 0);

        // R5 ignition done mid cycle cancels the timer
        go_ignite();
        ihb_lim_hi = 1; ihb_lim_lo = 1;
        repeat (10) tick();
        eoi_reached = 1;
        tick();
        check_eq("R5 run entry", int'(phase), P_RUN);
        ihb_lim_hi = 0; ihb_chk_lo = 1;
        wait_latch(n);
        check_eq("R5 fresh cycle time", n, FAST_CYC + 1);

        // R5 ignition done in the cycle the reduced cycle ends
        go_ignite();
        ihb_lim_hi = 1; ihb_lim_lo = 1;
        repeat (FAST_CYC) tick();
        eoi_reached = 1;
        tick();
        check_eq("R5 collision phase", int'(phase), P_RUN);

        // R6 run reduced cycle latch and no-latch
        go_run();
        ihb_lim_lo = 1; ihb_chk_lo = 1;
        wait_latch(n);
        check_eq("R6 run latch time", n, FAST_CYC + 1);
        go_run();
        ihb_lim_lo = 1;
        repeat (FAST_CYC + 5) tick();
        check_eq("R6 below check level", int'(phase), P_RUN);

        // R7 EOL blanked in ignition, acted on in run
        go_ignite();
        eol_viol = 1;
        repeat (100) tick();
        check_eq("R7 blanked phase", int'(phase), P_IGN);
        eoi_reached = 1;
        tick();
        wait_latch(n);
        check_eq("R7 eol latch time", n, PRE_CYC + 1);
        go_run();
        eol_viol = 1;
        tick();
        eol_viol = 0;
        repeat (PRE_CYC + 3) tick();
        check_eq("R7 transient eol", int'(phase), P_RUN);

        // R8 static over-voltage
        go_run();
        sovp_flag = 1;
        wait_latch(n);
        check_eq("R8 ovp latch time", n, PRE_CYC + 1);

        // R9 anti-saturation beats ignition done
        go_ignite();
        ihb_sat = 1; eoi_reached = 1;
        tick();
        check_eq("R9 priority", int'(phase), P_LAT);

        // R10 shutdown and restart
        go_run();
        shutdown_req = 1;
        tick();
        check_eq("R10 off", int'(phase), P_OFF);
        check_eq("R10 hb_en", int'(hb_en), 0);
        repeat (3) tick();
        check_eq("R10 held off", int'(phase), P_OFF);
        shutdown_req = 0;
        tick();
        check_eq("R10 restart", int'(phase), P_PRE);

        // R10 and R11 latched ignores shutdown, left by power loss
        go_run();
        ihb_cap_mode = 1;
        tick();
        ihb_cap_mode = 0;
        shutdown_req = 1;
        repeat (3) tick();
        check_eq("R10 latched shutdown", int'(phase), P_LAT);
        shutdown_req = 0;
        repeat (3) tick();
        check_eq("R11 still latched", int'(latched), 1);
        check_eq("R11 hb_en", int'(hb_en), 0);
        supply_ok = 0;
        tick();
        check_eq("R11 power loss", int'(phase), P_OFF);
        check_eq("R11 latch cleared", int'(latched), 0);
        supply_ok = 1;
        tick();
        check_eq("R11 restart", int'(phase), P_PRE);

        finish_run();
    end
endmodule